// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Access Controller

This controller drives a DRAM array split into two banks. Byte address bit 2 picks the bank, so consecutive 32-bit doublewords sit in alternating banks. A processor-side bus cycle is presented as a level request with an address. The request is held until the controller answers with a single-clock ready pulse. For each access the controller opens a row in the chosen bank, moves the multiplexed address lines from row to column, strobes CAS, and then closes the row.

Each bank has its own precharge timer. The timer starts when that bank's RAS goes inactive and counts down on every clock, whatever the other bank is doing. A new access is held back only when it targets a bank whose timer has not yet expired. An access to the other bank starts at once. An access that follows enough idle clocks also starts at once. A steady run of sequential doublewords therefore never waits for precharge.

Top module: `ilv_dram_ctrl`

## Requirements
- R1: Byte address bit 2 selects the bank: 0 drives `ras_n_o[0]`/`cas_n_o[0]`, 1 drives `ras_n_o[1]`/`cas_n_o[1]`; the strobes of the other bank stay high for the whole access.
- R2: The row is byte address bits [3+MAW +: MAW] and the column is bits [3 +: MAW]. In the first access clock `ma_o` carries the row with RAS low. In the next clock `ma_o` carries the column with CAS still high. CAS goes low in the clock after that, with `ma_o` unchanged.
- R3: If the controller is idle and the target bank is free in the clock a request is first seen, the row clock follows at once and `ready_o` is high in the (2+CAS_CLKS)-th clock after the request clock. `ready_o` lasts exactly one clock, and it coincides with the last of CAS_CLKS clocks of CAS low.
- R4: Between two accesses, each bank's RAS stays high for at least PRECH clocks.
- R5: A request to a bank that is still precharging waits with all strobes high. Its row clock is the clock after the one in which that bank has been RAS-high for PRECH clocks.
- R6: A request to the bank not used by the previous access starts without any precharge stall.
- R7: Idle clocks after an access count toward its bank's precharge. Once PRECH-1 idle clocks have passed, a request to the same bank starts without a stall; after fewer idle clocks it waits only the remaining difference.
- R8: Ascending consecutive doublewords issued back to back complete with no precharge stall.
- R9: At most one bank has RAS low at any clock, and CAS of a bank is low only while that bank's RAS is low.
- R10: During and right after reset, all RAS and CAS strobes and `we_n_o` are high and `ready_o` is low.
- R11: `we_n_o` is low for every clock of an access whose request had `we_i` high, and high for read accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus cycle request, held until ready |
| we_i | input | 1 | Request is a write |
| addr_i | input | 2*MAW+1 | Byte address bits [2*MAW+2:2] |
| ready_o | output | 1 | Bus cycle completes in this clock |
| ras_n_o | output | 2 | Row strobe per bank, active low |
| cas_n_o | output | 2 | Column strobe per bank, active low |
| ma_o | output | MAW | Multiplexed row/column address |
| we_n_o | output | 1 | DRAM write enable, active low |

## Verification
Two things can fall in the same clock: a bank's precharge countdown reaching zero, and the decode of a new request to that same bank. The bench provokes this by inserting exactly PRECH-1 idle clocks, and then PRECH-2, after an access. It expects no stall in the first case and exactly one stall clock in the second. A second overlap is one bank's timer reloading while the other bank's timer is still counting. This is reached with alternating and same-bank sequences. In every case the bench judges the clock in which `ready_o` arrives and the strobe pattern in the row, column-setup and CAS clocks against a bank-free schedule it keeps itself.

// File: rtl/ilv_dram_pkg.sv
package ilv_dram_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_STALL,
    SQ_ROW,
    SQ_MUX,
    SQ_CAS
  } seq_state_e;

  // Width of a counter that must hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Timer reload: the counter reads zero after prech RAS-high clocks.
  function automatic int unsigned prech_reload(input int unsigned prech);
    return (prech == 0) ? 0 : prech - 1;
  endfunction

  // CAS clocks still to go after the first CAS clock.
  function automatic int unsigned cas_reload(input int unsigned cas_clks);
    return (cas_clks == 0) ? 0 : cas_clks - 1;
  endfunction

endpackage

// File: rtl/ilv_prech_timer.sv
module ilv_prech_timer
  import ilv_dram_pkg::*;
#(
  parameter int unsigned PRECH = 3,
  localparam int unsigned CW = cnt_width(PRECH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic close_i,
  output logic busy_o
);

  localparam logic [CW-1:0] LOAD = CW'(prech_reload(PRECH));

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (close_i) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ilv_access_seq.sv
module ilv_access_seq
  import ilv_dram_pkg::*;
#(
  parameter int unsigned CAS_CLKS = 1,
  localparam int unsigned CW = cnt_width(CAS_CLKS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       tgt_busy_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       stall_o,
  output logic       row_o,
  output logic       mux_o,
  output logic       cas_o,
  output logic       last_o
);

  localparam logic [CW-1:0] CAS_LOAD = CW'(cas_reload(CAS_CLKS));

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cas_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (req_i) st_d = tgt_busy_i ? SQ_STALL : SQ_ROW;
      SQ_STALL: if (!tgt_busy_i) st_d = SQ_ROW;
      SQ_ROW:   st_d = SQ_MUX;
      SQ_MUX:   st_d = SQ_CAS;
      SQ_CAS:   if (cas_q == '0) st_d = SQ_IDLE;
      default:  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cas_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == SQ_MUX) begin
        cas_q <= CAS_LOAD;
      end else if (st_q == SQ_CAS && cas_q != '0) begin
        cas_q <= cas_q - CW'(1);
      end
    end
  end

  assign state_o  = st_q;
  assign accept_o = (st_q == SQ_IDLE) && req_i;
  assign stall_o  = (st_q == SQ_STALL);
  assign row_o    = (st_q == SQ_ROW);
  assign mux_o    = (st_q == SQ_MUX);
  assign cas_o    = (st_q == SQ_CAS);
  assign last_o   = (st_q == SQ_CAS) && (cas_q == '0);

endmodule

// File: rtl/ilv_addr_path.sv
module ilv_addr_path #(
  parameter int unsigned MAW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic [2*MAW+2:2] addr_i,
  input  logic             we_i,
  input  logic             col_sel_i,
  output logic             bank_o,
  output logic             we_o,
  output logic [MAW-1:0]   ma_o
);

  logic [2*MAW+2:2] addr_q;
  logic             we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b0;
    end else if (capture_i) begin
      addr_q <= addr_i;
      we_q   <= we_i;
    end
  end

  assign bank_o = addr_q[2];
  assign we_o   = we_q;
  assign ma_o   = col_sel_i ? addr_q[3 +: MAW] : addr_q[3+MAW +: MAW];

endmodule

// File: rtl/ilv_dram_ctrl.sv
module ilv_dram_ctrl
  import ilv_dram_pkg::*;
#(
  parameter int unsigned MAW      = 9,
  parameter int unsigned PRECH    = 3,
  parameter int unsigned CAS_CLKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2*MAW+2:2] addr_i,
  output logic             ready_o,
  output logic [1:0]       ras_n_o,
  output logic [1:0]       cas_n_o,
  output logic [MAW-1:0]   ma_o,
  output logic             we_n_o
);

  localparam int unsigned NB = 2;

  seq_state_e    state_w;
  logic          accept_w, stall_w, row_w, mux_w, cas_w, done_w, active_w;
  logic          bank_q, we_q, tgt_bank_w, tgt_busy_w;
  logic [NB-1:0] busy_w, close_w;

  // While idle the live address picks the bank; while stalled, the captured one.
  assign tgt_bank_w = (state_w == SQ_IDLE) ? addr_i[2] : bank_q;
  assign tgt_busy_w = busy_w[tgt_bank_w];

  ilv_access_seq #(.CAS_CLKS(CAS_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .tgt_busy_i (tgt_busy_w),
    .state_o    (state_w),
    .accept_o   (accept_w),
    .stall_o    (stall_w),
    .row_o      (row_w),
    .mux_o      (mux_w),
    .cas_o      (cas_w),
    .last_o     (done_w)
  );

  ilv_addr_path #(.MAW(MAW)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (accept_w),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .col_sel_i (mux_w | cas_w),
    .bank_o    (bank_q),
    .we_o      (we_q),
    .ma_o      (ma_o)
  );

  assign active_w = row_w | mux_w | cas_w;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic BIDX = 1'(b);

    assign close_w[b] = done_w && (bank_q == BIDX);

    ilv_prech_timer #(.PRECH(PRECH)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .close_i (close_w[b]),
      .busy_o  (busy_w[b])
    );

    assign ras_n_o[b] = ~(active_w && (bank_q == BIDX));
    assign cas_n_o[b] = ~(cas_w && (bank_q == BIDX));
  end

  assign ready_o = done_w;
  assign we_n_o  = ~(active_w && we_q);

endmodule

// File: rtl/ilv_dram_chk.sv
module ilv_dram_chk
  import ilv_dram_pkg::*;
#(
  parameter int unsigned MAW   = 9,
  parameter int unsigned PRECH = 3,
  localparam int unsigned CW = cnt_width(PRECH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ready_o,
  input logic [1:0]     ras_n_o,
  input logic [1:0]     cas_n_o,
  input logic [MAW-1:0] ma_o,
  input logic           accept_w,
  input logic           stall_w,
  input logic           row_w,
  input logic           tgt_busy_w
);

  AST_SINGLE_ROW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ras_n_o) <= 1); // R9

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cas_n_o) & ras_n_o) == 2'b00); // R9

  AST_READY_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o); // R3

  AST_READY_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cas_n_o != 2'b11)); // R3

  AST_FREE_STARTS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !tgt_busy_w) |=> row_w); // R6

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_w && tgt_busy_w) |=> (stall_w && ras_n_o == 2'b11)); // R5

  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_w && !tgt_busy_w) |=> row_w); // R5

  for (genvar b = 0; b < 2; b++) begin : g_b
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q <= CW'(PRECH);
      end else if (!ras_n_o[b]) begin
        run_q <= '0;
      end else if (run_q != CW'(PRECH)) begin
        run_q <= run_q + CW'(1);
      end
    end

    AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n_o[b]) |-> (run_q >= CW'(PRECH))); // R4

    AST_COLUMN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n_o[b]) |-> ($stable(ma_o) && $past(!ras_n_o[b]))); // R2
  end

endmodule

bind ilv_dram_ctrl ilv_dram_chk #(.MAW(MAW), .PRECH(PRECH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready_o    (ready_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .ma_o       (ma_o),
  .accept_w   (accept_w),
  .stall_w    (stall_w),
  .row_w      (row_w),
  .tgt_busy_w (tgt_busy_w)
);

// File: tb/sim_ilv_dram_ctrl.sv
module sim_ilv_dram_ctrl;

  localparam int MAW   = 9;
  localparam int PRECH = 4;
  localparam int CASN  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req = 1'b0;
  logic             we = 1'b0;
  logic [2*MAW+2:2] addr = '0;
  logic             ready;
  logic [1:0]       ras_n, cas_n;
  logic [MAW-1:0]   ma;
  logic             we_n;

  longint cyc = 0;
  longint free_at [2];
  int     n_chk = 0;
  int     n_bad = 0;
  bit     done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_dram_ctrl #(.MAW(MAW), .PRECH(PRECH), .CAS_CLKS(CASN)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .ready_o (ready),
    .ras_n_o (ras_n),
    .cas_n_o (cas_n),
    .ma_o    (ma),
    .we_n_o  (we_n)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus cycle; returns the precharge stall measured at the ports.
  task automatic bus_cycle(input logic [31:0] a, input logic w, output int stall);
    int             b;
    longint         d, row, rdy;
    logic [MAW-1:0] r, c;
    logic [1:0]     on;
    bit             got;
    b   = int'(a[2]);
    r   = a[3+MAW +: MAW];
    c   = a[3 +: MAW];
    on  = (b == 1) ? 2'b01 : 2'b10;
    d   = cyc;
    row = ((d > free_at[b]) ? d : free_at[b]) + 1;
    rdy = row + 1 + CASN;
    addr = a[2*MAW+2:2];
    we   = w;
    req  = 1'b1;
    got  = 1'b0;
    for (int k = 0; k < 400 && !got; k++) begin
      @(negedge clk);
      if (cyc == row - 1)
        chk(ras_n == 2'b11, "R4", "ras_n before row clock", ras_n, 2'b11);
      if (cyc == row) begin
        chk(ras_n == on, "R1", "ras_n in row clock", ras_n, on);
        chk(ma == r && cas_n == 2'b11, "R2", "row address", ma, r);
      end
      if (cyc == row + 1)
        chk(ma == c && cas_n == 2'b11 && ras_n == on, "R2", "column setup", ma, c);
      if (ready) begin
        got = 1'b1;
        chk(cyc == rdy, "R3", "ready clock", cyc, rdy);
        chk(cas_n == on, "R1", "cas_n at ready", cas_n, on);
        chk(ras_n == on && ma == c, "R9", "other bank idle at ready", ras_n, on);
        chk(we_n == !w, "R11", "we_n during access", we_n, !w);
      end
    end
    if (!got) chk(1'b0, "R3", "ready never seen", 0, rdy);
    stall = int'(cyc - d - 2 - CASN);
    free_at[b] = cyc + PRECH;
    req = 1'b0;
    we  = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ras_n == 2'b11, "R10", "ras_n in reset", ras_n, 2'b11);
    chk(cas_n == 2'b11, "R10", "cas_n in reset", cas_n, 2'b11);
    chk(ready == 1'b0 && we_n == 1'b1, "R10", "ready/we_n in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n == 2'b11 && cas_n == 2'b11, "R10", "strobes after reset", {ras_n, cas_n}, 4'hf);
  endtask

  task automatic t_alternate();
    int s;
    idle(PRECH);
    for (int i = 0; i < 8; i++) begin
      bus_cycle(32'h0000_1100 + 32'(4 * i), 1'(i % 2), s);
      chk(s == 0, "R8", "sequential stall", s, 0);
    end
  endtask

  task automatic t_same_bank();
    int s;
    idle(PRECH);
    bus_cycle(32'h0000_2200, 1'b0, s);
    chk(s == 0, "R3", "first access stall", s, 0);
    bus_cycle(32'h0000_2208, 1'b1, s);
    chk(s == PRECH - 1, "R5", "same bank back to back", s, PRECH - 1);
    bus_cycle(32'h0000_2210, 1'b0, s);
    chk(s == PRECH - 1, "R5", "third same bank access", s, PRECH - 1);
  endtask

  task automatic t_opposite();
    int s;
    idle(PRECH);
    bus_cycle(32'h0000_3300, 1'b0, s);
    bus_cycle(32'h0000_3344, 1'b0, s);
    chk(s == 0, "R6", "bank 0 then bank 1", s, 0);
    bus_cycle(32'h0000_33A0, 1'b1, s);
    chk(s == 0, "R6", "bank 1 then bank 0", s, 0);
  endtask

  task automatic t_idle();
    int s;
    idle(PRECH);
    bus_cycle(32'h0000_4404, 1'b0, s);
    idle(PRECH - 1);
    bus_cycle(32'h0000_4414, 1'b0, s);
    chk(s == 0, "R7", "same bank after full idle", s, 0);
    idle(PRECH - 2);
    bus_cycle(32'h0000_4424, 1'b0, s);
    chk(s == 1, "R7", "same bank after short idle", s, 1);
  endtask

  task automatic t_addr_edges();
    int s;
    idle(PRECH);
    bus_cycle(32'h001F_FFFC, 1'b1, s);
    chk(s == 0, "R1", "all-ones address stall", s, 0);
    bus_cycle(32'h000A_AAA8, 1'b0, s);
    chk(s == 0, "R2", "alternating pattern stall", s, 0);
    bus_cycle(32'h0015_5550, 1'b0, s);
    chk(s == PRECH - 1, "R5", "bank 0 revisit", s, PRECH - 1);
  endtask

  initial begin
    free_at[0] = 0;
    free_at[1] = 0;
    t_reset();
    t_alternate();
    t_same_bank();
    t_opposite();
    t_idle();
    t_addr_edges();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog act=%0d exp=finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule